// File: doc/BRIEF.md
# Programmable Tag Propagation Unit

This block computes the security tag written alongside the result of each executed instruction. The pipeline reports the instruction's class code, the tags of its source operands, whether a second source exists, and the tag currently held by the destination. The block returns the destination's new tag in the same cycle, so tag tracking adds no pipeline stage.

The combining rule is chosen at run time. A 17-bit configuration register holds one 2-bit rule field for each of eight instruction classes, plus a global enable bit. Software writes and reads this register through a simple address/data control-register port. Each rule can keep the old destination tag, AND the source tags, OR the source tags, or force the tag to zero. Decoding instructions into classes is done elsewhere. The register file that stores the tags is also outside this block.

Top module: `tag_prop_unit`

## Requirements
- R1: After reset the configuration register reads as zero, and `new_tag` is 0 for any operand tags.
- R2: A write with `csr_we`=1 and `csr_addr`=`CFG_ADDR` stores `csr_wdata[16:0]` at the next rising clock edge. A read at `CFG_ADDR` returns those 17 bits, and bits 31:17 read as zero.
- R3: A write to any other address leaves the configuration register unchanged.
- R4: When the enable bit (bit 16) is 0, `new_tag` is 0 whatever the rule fields and operand tags are.
- R5: Rule code 2'b00 (keep) makes `new_tag` equal `old_tag`.
- R6: Rule code 2'b01 (all) makes `new_tag` = `src1_tag` AND effective second tag.
- R7: Rule code 2'b10 (any) makes `new_tag` = `src1_tag` OR effective second tag.
- R8: Rule code 2'b11 (clear) makes `new_tag` 0.
- R9: Class code k selects the rule field at bits [2k+1:2k]. The classes are 0 arithmetic, 1 logical, 2 shift, 3 comparison, 4 jump, 5 branch, 6 load, 7 store.
- R10: When `src2_used` is 0, the effective second tag is 0, whatever the value of `src2_tag`.
- R11: `new_tag` depends combinationally on the operand inputs and takes its value in the same cycle those inputs are applied.
- R12: A read at any address other than `CFG_ADDR` returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_we | input | 1 | Control-register write strobe |
| csr_addr | input | 12 | Control-register address |
| csr_wdata | input | 32 | Control-register write data |
| csr_rdata | output | 32 | Control-register read data |
| ins_class | input | 3 | Instruction class code |
| src1_tag | input | 1 | Tag of first source operand |
| src2_tag | input | 1 | Tag of second source operand |
| src2_used | input | 1 | Instruction has a second source |
| old_tag | input | 1 | Current tag of the destination |
| new_tag | output | 1 | Tag to write to the destination |

## Verification
The bench builds the block with its default parameters: eight classes, 2-bit rules, a 12-bit address and a 32-bit data path. With eight classes, every class code maps to a field, so each field position can be reached with a distinct rule pattern. The 32-bit data path leaves 15 upper bits that can be driven to check that they read back as zero. Operand tag combinations are swept under every rule code, with the second source both present and absent. Writes to a neighbouring address are followed by readbacks to confirm they have no effect.

// File: rtl/tagprop_pkg.sv
package tagprop_pkg;
  localparam int TP_NUM_CLS = 8;
  localparam int TP_RULE_W  = 2;

  typedef enum logic [1:0] {
    RULE_KEEP = 2'b00,
    RULE_ALL  = 2'b01,
    RULE_ANY  = 2'b10,
    RULE_CLR  = 2'b11
  } rule_e;

  typedef enum logic [2:0] {
    CLS_ARITH = 3'd0,
    CLS_LOGIC = 3'd1,
    CLS_SHIFT = 3'd2,
    CLS_CMP   = 3'd3,
    CLS_JUMP  = 3'd4,
    CLS_BRAN  = 3'd5,
    CLS_LOAD  = 3'd6,
    CLS_STORE = 3'd7
  } ins_class_e;

  // Tag combining function for one rule
  function automatic logic combine_tag(rule_e r, logic a, logic b, logic old);
    logic res;
    unique case (r)
      RULE_KEEP: res = old;
      RULE_ALL:  res = a & b;
      RULE_ANY:  res = a | b;
      default:   res = 1'b0;
    endcase
    return res;
  endfunction
endpackage

// File: rtl/tp_cfg_reg.sv
module tp_cfg_reg #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int CFG_W  = 17,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h7C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic [CFG_W-1:0]  cfg_q
);
  logic addr_hit;
  logic wr_hit;
  logic wr_miss;

  assign addr_hit = (addr == CFG_ADDR);
  assign wr_hit   = we & addr_hit;
  assign wr_miss  = we & ~addr_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cfg_q <= '0;
    else if (wr_hit) cfg_q <= wdata[CFG_W-1:0];
  end

  always_comb begin
    rdata = '0;
    if (addr_hit) rdata[CFG_W-1:0] = cfg_q;
  end

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit |=> cfg_q == $past(wdata[CFG_W-1:0]));
  assert_miss_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_miss |=> $stable(cfg_q));
  assert_read_zero_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !addr_hit |-> rdata == '0);
endmodule

// File: rtl/tp_rule_sel.sv
module tp_rule_sel
  import tagprop_pkg::*;
#(
  parameter int NUM_CLS = 8,
  parameter int RULE_W  = 2,
  localparam int CLS_W   = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1,
  localparam int FIELD_W = NUM_CLS * RULE_W
) (
  input  logic [FIELD_W-1:0] fields,
  input  logic [CLS_W-1:0]   cls,
  output rule_e              rule
);
  logic [RULE_W-1:0] per_cls [NUM_CLS];

  for (genvar k = 0; k < NUM_CLS; k++) begin : g_unpack
    assign per_cls[k] = fields[k*RULE_W +: RULE_W];
  end

  logic cls_ok;
  assign cls_ok = ({1'b0, cls} < (CLS_W+1)'(NUM_CLS));
  assign rule   = cls_ok ? rule_e'(per_cls[cls]) : RULE_CLR;
endmodule

// File: rtl/tag_prop_unit.sv
module tag_prop_unit
  import tagprop_pkg::*;
#(
  parameter int NUM_CLS = TP_NUM_CLS,
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 32,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 12'h7C0,
  localparam int RULE_W  = TP_RULE_W,
  localparam int FIELD_W = NUM_CLS * RULE_W,
  localparam int CFG_W   = FIELD_W + 1,
  localparam int CLS_W   = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              csr_we,
  input  logic [ADDR_W-1:0] csr_addr,
  input  logic [DATA_W-1:0] csr_wdata,
  output logic [DATA_W-1:0] csr_rdata,
  input  logic [CLS_W-1:0]  ins_class,
  input  logic              src1_tag,
  input  logic              src2_tag,
  input  logic              src2_used,
  input  logic              old_tag,
  output logic              new_tag
);
  logic [CFG_W-1:0] cfg_q;
  logic             prop_en;
  rule_e            sel_rule;
  logic             eff_src2;

  tp_cfg_reg #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CFG_W(CFG_W), .CFG_ADDR(CFG_ADDR)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(csr_we), .addr(csr_addr),
    .wdata(csr_wdata), .rdata(csr_rdata), .cfg_q(cfg_q)
  );

  assign prop_en = cfg_q[CFG_W-1];

  tp_rule_sel #(.NUM_CLS(NUM_CLS), .RULE_W(RULE_W)) u_sel (
    .fields(cfg_q[FIELD_W-1:0]), .cls(ins_class), .rule(sel_rule)
  );

  assign eff_src2 = src2_used & src2_tag;
  assign new_tag  = prop_en & combine_tag(sel_rule, src1_tag, eff_src2, old_tag);

  assert_off_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !prop_en |-> !new_tag);
  assert_keep_old_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_en && sel_rule == RULE_KEEP) |-> new_tag == old_tag);
  assert_all_needs_src1_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_en && sel_rule == RULE_ALL && new_tag) |-> src1_tag);
  assert_any_from_src1_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prop_en && sel_rule == RULE_ANY && src1_tag) |-> new_tag);
  assert_clr_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_rule == RULE_CLR) |-> !new_tag);
  assert_solo_src_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!src2_used && sel_rule == RULE_ALL) |-> !new_tag);
endmodule

// File: tb/tb_tag_prop_unit.sv
module tb_tag_prop_unit;
  localparam int PERIOD = 10;
  localparam logic [11:0] CFG_ADDR = 12'h7C0;

  logic clk = 0, rst_n = 0, csr_we = 0;
  logic [11:0] csr_addr = CFG_ADDR;
  logic [31:0] csr_wdata = '0, csr_rdata;
  logic [2:0] ins_class = '0;
  logic src1_tag = 0, src2_tag = 0, src2_used = 1, old_tag = 0, new_tag;

  always #(PERIOD/2) clk = ~clk;

  tag_prop_unit dut (
    .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
    .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .ins_class(ins_class),
    .src1_tag(src1_tag), .src2_tag(src2_tag), .src2_used(src2_used),
    .old_tag(old_tag), .new_tag(new_tag)
  );

  typedef struct {
    logic        tag;
    logic [31:0] rd;
    string       req;
  } item_t;

  item_t sb_q[$];
  int n_chk = 0, n_fail = 0;
  logic [16:0] shadow = '0;

  function automatic logic model(logic [16:0] c, int cls, logic a, logic b,
                                 logic bu, logic old);
    logic [1:0] r;
    logic bb;
    r  = c[2*cls +: 2];
    bb = bu ? b : 1'b0;
    if (!c[16]) return 1'b0;
    if (r == 2'd0) return old;
    if (r == 2'd1) return a && bb;
    if (r == 2'd2) return a || bb;
    return 1'b0;
  endfunction

  task automatic csr_write(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    csr_we = 1; csr_addr = a; csr_wdata = d;
    if (a == CFG_ADDR) shadow = d[16:0];
  endtask

  task automatic apply(int cls, logic a, logic b, logic bu, logic old,
                       logic [11:0] ra, string req);
    item_t it;
    @(negedge clk);
    csr_we = 0; csr_addr = ra; ins_class = 3'(cls);
    src1_tag = a; src2_tag = b; src2_used = bu; old_tag = old;
    it.tag = model(shadow, cls, a, b, bu, old);
    it.rd  = (ra == CFG_ADDR) ? {15'd0, shadow} : 32'd0;
    it.req = req;
    sb_q.push_back(it);
  endtask

  // Monitor: samples a quarter period after the driving edge
  initial begin
    forever begin
      @(negedge clk);
      #(PERIOD/4);
      while (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_chk += 2;
        if (new_tag !== it.tag) begin
          n_fail++;
          $display("FAIL %s new_tag actual=%b expected=%b", it.req, new_tag, it.tag);
        end
        if (csr_rdata !== it.rd) begin
          n_fail++;
          $display("FAIL %s csr_rdata actual=%h expected=%h", it.req, csr_rdata, it.rd);
        end
      end
    end
  end

  bit finished = 0;
  initial begin
    #(PERIOD*20000);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    apply(0, 1, 1, 1, 1, CFG_ADDR, "R1");
    rst_n = 1;
    apply(2, 1, 1, 1, 1, CFG_ADDR, "R1");
    // R4: rules set to any, enable off
    csr_write(CFG_ADDR, 32'h0000_AAAA);
    for (int c = 0; c < 8; c++) apply(c, 1, 1, 1, 1, CFG_ADDR, "R4");
    // R5..R8 on arithmetic class, full operand sweep (R11 same-cycle)
    for (int r = 0; r < 4; r++) begin
      string rq;
      rq = (r == 0) ? "R5" : (r == 1) ? "R6" : (r == 2) ? "R7" : "R8";
      csr_write(CFG_ADDR, 32'h0001_0000 | r);
      for (int v = 0; v < 8; v++)
        apply(0, v[0], v[1], 1, v[2], CFG_ADDR, rq);
    end
    apply(0, 1, 0, 1, 1, CFG_ADDR, "R11");
    apply(0, 0, 1, 1, 0, CFG_ADDR, "R11");
    // R9: distinct rule per class, class k gets rule k%4
    csr_write(CFG_ADDR, 32'h0001_E4E4);
    for (int c = 0; c < 8; c++) begin
      apply(c, 1, 0, 1, 1, CFG_ADDR, "R9");
      apply(c, 1, 1, 1, 0, CFG_ADDR, "R9");
    end
    // R9: reversed pattern
    csr_write(CFG_ADDR, 32'h0001_1B1B);
    for (int c = 0; c < 8; c++) apply(c, 1, 0, 1, 1, CFG_ADDR, "R9");
    // R10: second source absent
    csr_write(CFG_ADDR, 32'h0001_0009); // class0 all, class1 any
    apply(0, 1, 1, 0, 1, CFG_ADDR, "R10");
    apply(1, 0, 1, 0, 0, CFG_ADDR, "R10");
    apply(1, 1, 1, 0, 0, CFG_ADDR, "R10");
    apply(0, 1, 1, 1, 0, CFG_ADDR, "R10");
    // R3: write elsewhere ignored
    csr_write(CFG_ADDR + 12'd1, 32'h0000_0000);
    apply(0, 1, 1, 1, 0, CFG_ADDR, "R3");
    apply(1, 1, 0, 1, 0, CFG_ADDR, "R3");
    // R12: read elsewhere gives zero
    apply(0, 0, 0, 1, 0, CFG_ADDR + 12'd1, "R12");
    apply(0, 0, 0, 1, 0, 12'h000, "R12");
    // R2: upper bits dropped on readback
    csr_write(CFG_ADDR, 32'hFFFF_FFFF);
    apply(3, 0, 0, 1, 1, CFG_ADDR, "R2");
    csr_write(CFG_ADDR, 32'h5A5A_5A5A);
    apply(5, 1, 0, 1, 0, CFG_ADDR, "R2");
    repeat (2) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule